// File: doc/BRIEF.md
# Triple Channel Prescaled Interval Timer

This block is a bus-attached timer peripheral holding three independent 16-bit up-counters. Every channel has its own prescaler with power-of-two division, a stop control, a choice between a free-running count that wraps at its top value and an interval count that wraps at a programmable limit, and an interrupt line that stays asserted while an enabled event is pending. Software programs the channels through a 32-bit register bank with separate read and write strobes.

The registers are grouped by function. Each group holds one word per channel, so channel n's copy sits 4*n bytes above the group's base. A read returns its data on `bus_rdata` in the cycle after the read strobe, and `bus_rdata` is zero in every other cycle. Reading a channel's status word acknowledges its pending event. The usual way to arm an interval is to write the limit while the channel is stopped. A single control write then clears the stop bit and requests a restart, so the count begins again at zero against the new limit.

Top module: `tri_interval_timer`

## Requirements
- R1: Register groups sit at byte offsets 0x00 (clock control, bits [4:0] read/write), 0x0C (counter control, bits [1:0] read/write), 0x18 (count, read-only), 0x24 (interval, bits [15:0] read/write), 0x54 (status, read-only) and 0x60 (enable, bit 0 read/write). Channel n of each group is at base+4*n, and channels do not affect one another. Read data appears on `bus_rdata` one cycle after `bus_rd` and is 0 in cycles with no read.
- R2: After reset every channel has counter control 0x1 (stopped), clock control 0, interval 0xFFFF, status 0, enable 0 and count 0, and no interrupt is asserted.
- R3: With counter control bit 0 clear and bit 1 clear, the count rises by one on every prescaled tick and wraps from 0xFFFF to 0.
- R4: While counter control bit 0 is set, the count holds its value. A write that sets the bit takes effect from the following cycle.
- R5: Writing counter control with bit 4 set forces the count and the prescaler phase to 0 at that clock edge. Bit 4 is not stored and always reads back as 0.
- R6: Clock control bit 0 enables the prescaler, and bits [4:1] hold N. When bit 0 is set, a running count advances once every 2^(N+1) clocks, with the first advance 2^(N+1) clocks after a restart. When bit 0 is clear, the count advances every clock.
- R7: With counter control bit 1 set, the count climbs to the interval value. On the next tick it returns to 0 and sets status bit 0.
- R8: Reading the status word returns its value and clears bit 0, unless an interval event occurs in that same cycle, in which case the bit stays set.
- R9: A channel's interrupt output is high exactly when status bit 0 and enable bit 0 are both set.
- R10: Writes to read-only or unmapped offsets change no state. Reads from unmapped or misaligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 3 | Level interrupt, one per channel |

## Verification
The bench builds the block with its default parameters: three channels, a 16-bit count and a 4-bit prescale selector. Because the count is 16 bits wide, a full free-running lap of 65536 ticks fits in the run, so the real 0xFFFF-to-0 wrap is observed rather than a shortened one. Three channels let the bench stop one channel, run free on another and run an interval on the third, which exercises the 4-byte stride and shows that the channels stay separate. The prescaler is checked with a divider of four, which confirms both the tick spacing and the phase reset on restart.

// File: rtl/timer_pkg.sv
// Shared constants for the triple channel timer.
// Assumes byte addressing with 32-bit words; each group holds one word per channel.
package timer_pkg;
    localparam int GRP_CLK   = 'h00;
    localparam int GRP_CNT   = 'h0C;
    localparam int GRP_VAL   = 'h18;
    localparam int GRP_IVL   = 'h24;
    localparam int GRP_STS   = 'h54;
    localparam int GRP_IEN   = 'h60;
    localparam int CH_STRIDE = 4;

    // Bit positions inside counter control
    localparam int CC_STOP    = 0;
    localparam int CC_IVLMODE = 1;
    localparam int CC_RESTART = 4;

    // Register group selector for one decoded access
    typedef enum logic [2:0] {
        SEL_NONE, SEL_CLK, SEL_CNT, SEL_VAL, SEL_IVL, SEL_STS, SEL_IEN
    } reg_sel_e;
endpackage

// File: rtl/timer_prescaler.sv
// Power-of-two clock divider producing the count-enable tick for one channel.
// Assumes psc_sel selects a division of 2^(psc_sel+1); restart zeroes the phase.
module timer_prescaler #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          psc_en,
    input  logic [NW-1:0] psc_sel,
    output logic          tick
);
    localparam int DIVW = 1 << NW;

    logic [NW:0]     shamt;
    logic [DIVW:0]   span;
    logic            span_unused;
    logic [DIVW-1:0] lim;
    logic [DIVW-1:0] div_q;

    // Terminal value of the divider for the selected ratio
    always_comb begin
        shamt       = {1'b0, psc_sel} + {{NW{1'b0}}, 1'b1};
        span        = {{DIVW{1'b0}}, 1'b1} << shamt;
        span_unused = span[DIVW];
        lim         = span[DIVW-1:0] - {{(DIVW-1){1'b0}}, 1'b1};
    end

    // Tick when running and either undivided or at the divider end
    assign tick = run && (!psc_en || (div_q == lim));

    // Divider phase counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (run && psc_en) begin
            div_q <= (div_q == lim) ? '0 : div_q + 1'b1;
        end
    end

    p_phase_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_q == '0));
endmodule

// File: rtl/timer_counter.sv
// Up-counter with free-running and interval modes for one channel.
// Assumes tick is a single-cycle enable; restart overrides counting.
module timer_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic          ivl_mode,
    input  logic [CW-1:0] ivl,
    output logic [CW-1:0] count,
    output logic          evt
);
    // Interval event when the limit has been reached on a tick
    assign evt = tick && ivl_mode && (count >= ivl);

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (tick) begin
            count <= evt ? '0 : count + 1'b1;
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count));
    p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));
    p_wrap_after_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !restart) |=> (count == '0));
endmodule

// File: rtl/timer_channel.sv
// One timer channel: its control registers, prescaler, counter and interrupt.
// Assumes write strobes are already decoded per register; rd_sts marks a status read.
module timer_channel #(
    parameter int CW = 16,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_clk,
    input  logic          wr_cnt,
    input  logic          wr_ivl,
    input  logic          wr_ien,
    input  logic          rd_sts,
    input  logic [CW-1:0] wdata,
    output logic [NW:0]   clk_ctrl,
    output logic [1:0]    cnt_ctrl,
    output logic [CW-1:0] count,
    output logic [CW-1:0] ivl,
    output logic          sts,
    output logic          ien,
    output logic          irq
);
    import timer_pkg::*;

    logic restart;
    logic tick;
    logic evt;

    assign restart = wr_cnt && wdata[CC_RESTART];

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_ctrl <= '0;
            cnt_ctrl <= 2'b01;
            ivl      <= '1;
            ien      <= 1'b0;
        end else begin
            if (wr_clk) clk_ctrl <= wdata[NW:0];
            if (wr_cnt) cnt_ctrl <= {wdata[CC_IVLMODE], wdata[CC_STOP]};
            if (wr_ivl) ivl      <= wdata;
            if (wr_ien) ien      <= wdata[0];
        end
    end

    // Pending event bit; a new event beats a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)      sts <= 1'b0;
        else if (evt)    sts <= 1'b1;
        else if (rd_sts) sts <= 1'b0;
    end

    assign irq = sts && ien;

    timer_prescaler #(.NW(NW)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!cnt_ctrl[0]),
        .restart (restart),
        .psc_en  (clk_ctrl[0]),
        .psc_sel (clk_ctrl[NW:1]),
        .tick    (tick)
    );

    timer_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .ivl_mode (cnt_ctrl[1]),
        .ivl      (ivl),
        .count    (count),
        .evt      (evt)
    );

    p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> sts);
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !evt) |=> !sts);
    p_stopped_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ctrl[0] |-> !tick);
endmodule

// File: rtl/tri_interval_timer.sv
// Three-channel prescaled interval timer with a shared register bank.
// Assumes single-cycle read/write strobes; read data is registered and zero when idle.
module tri_interval_timer #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 4,
    parameter int AW     = 8,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    import timer_pkg::*;

    logic [DW-1:0]     ch_rd   [NUM_CH];
    logic [NUM_CH-1:0] ch_hit;
    logic [DW-1:0]     rd_mux;
    logic              any_hit;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata[DW-1:CNT_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        reg_sel_e            sel;
        logic [PSC_W:0]      clk_ctrl;
        logic [1:0]          cnt_ctrl;
        logic [CNT_W-1:0]    count;
        logic [CNT_W-1:0]    ivl;
        logic                sts;
        logic                ien;

        // Address decode for this channel's word in every group
        always_comb begin
            unique case (int'(bus_addr))
                GRP_CLK + CH_STRIDE*c: sel = SEL_CLK;
                GRP_CNT + CH_STRIDE*c: sel = SEL_CNT;
                GRP_VAL + CH_STRIDE*c: sel = SEL_VAL;
                GRP_IVL + CH_STRIDE*c: sel = SEL_IVL;
                GRP_STS + CH_STRIDE*c: sel = SEL_STS;
                GRP_IEN + CH_STRIDE*c: sel = SEL_IEN;
                default:               sel = SEL_NONE;
            endcase
        end

        assign ch_hit[c] = (sel != SEL_NONE);

        timer_channel #(.CW(CNT_W), .NW(PSC_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_clk   (bus_wr && sel == SEL_CLK),
            .wr_cnt   (bus_wr && sel == SEL_CNT),
            .wr_ivl   (bus_wr && sel == SEL_IVL),
            .wr_ien   (bus_wr && sel == SEL_IEN),
            .rd_sts   (bus_rd && sel == SEL_STS),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .clk_ctrl (clk_ctrl),
            .cnt_ctrl (cnt_ctrl),
            .count    (count),
            .ivl      (ivl),
            .sts      (sts),
            .ien      (ien),
            .irq      (irq[c])
        );

        // Read value of the selected word of this channel
        always_comb begin
            ch_rd[c] = '0;
            case (sel)
                SEL_CLK: ch_rd[c] = DW'(clk_ctrl);
                SEL_CNT: ch_rd[c] = DW'(cnt_ctrl);
                SEL_VAL: ch_rd[c] = DW'(count);
                SEL_IVL: ch_rd[c] = DW'(ivl);
                SEL_STS: ch_rd[c] = DW'(sts);
                SEL_IEN: ch_rd[c] = DW'(ien);
                default: ch_rd[c] = '0;
            endcase
        end
    end

    // Merge the per-channel read values
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) rd_mux |= ch_rd[c];
    end

    assign any_hit = |ch_hit;

    // Registered read data, zero when no read
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    p_one_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_hit));
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !any_hit) |=> (bus_rdata == '0));
endmodule

// File: tb/tri_interval_timer_tb_top.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module tri_interval_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] irq;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] ra(int base, int ch);
        return 8'(base + 4*ch);
    endfunction

    // All tasks start and end at a falling edge, each op spans one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
    endtask

    // Monitor: mark rising edges that carried a read
    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare returned data against the queue
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R1 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk(32'(irq), 0, "R2 irq after reset");
        chk(bus_rdata, 0, "R1 idle rdata");
        // R2 reset values
        rd(ra('h00,1), 32'h0,    "R2 clk ctrl");
        rd(ra('h0C,1), 32'h1,    "R2 cnt ctrl");
        rd(ra('h24,1), 32'hFFFF, "R2 interval");
        rd(ra('h54,1), 32'h0,    "R2 status");
        rd(ra('h60,1), 32'h0,    "R2 enable");
        rd(ra('h18,1), 32'h0,    "R2 count");
        // R10 unmapped and read-only
        rd(8'h30, 32'h0, "R10 unmapped read");
        rd(8'h02, 32'h0, "R10 misaligned read");
        wr(ra('h18,0), 32'h1234);
        wr(ra('h54,0), 32'h1);
        wr(8'h30, 32'hFFFF);
        rd(ra('h18,0), 32'h0,    "R10 count write ignored");
        rd(ra('h54,0), 32'h0,    "R10 status write ignored");
        rd(ra('h24,0), 32'hFFFF, "R10 interval untouched");
        // R1 clock control readback, R5 restart bit not stored
        wr(ra('h00,0), 32'h1F);
        rd(ra('h00,0), 32'h1F, "R1 clk ctrl rw");
        rd(ra('h00,1), 32'h0,  "R1 neighbour untouched");
        wr(ra('h00,0), 32'h0);
        wr(ra('h0C,0), 32'h13);
        rd(ra('h0C,0), 32'h3, "R5 restart reads 0");
        // R3 free run: restart at P0, read after n idle returns n
        wr(ra('h0C,0), 32'h10);
        idle(9);
        rd(ra('h18,0), 32'd9,  "R3 count 9");
        rd(ra('h18,0), 32'd10, "R3 count 10");
        // R4 stop at P0+12: the increment at that edge still lands
        wr(ra('h0C,0), 32'h1);
        idle(5);
        rd(ra('h18,0), 32'd12, "R4 held");
        rd(ra('h18,0), 32'd12, "R4 still held");
        rd(ra('h18,1), 32'd0,  "R1 stopped channel 1 count");
        // R6 prescaler N=1 divides by 4
        wr(ra('h00,0), 32'h3);
        wr(ra('h0C,0), 32'h10);
        idle(9);
        rd(ra('h18,0), 32'd2, "R6 div4 after 9");
        idle(2);
        rd(ra('h18,0), 32'd3, "R6 div4 after 12");
        // R3 full wrap, prescaler off
        wr(ra('h00,0), 32'h0);
        wr(ra('h0C,0), 32'h10);
        idle(65535);
        rd(ra('h18,0), 32'hFFFF, "R3 top value");
        rd(ra('h18,0), 32'h0,    "R3 wrap to 0");
        wr(ra('h0C,0), 32'h1);
        // R7/R8/R9 interval on channel 2, limit 4
        wr(ra('h60,2), 32'h1);
        wr(ra('h0C,2), 32'h3);
        wr(ra('h24,2), 32'h4);
        wr(ra('h0C,2), 32'h12);
        idle(4);
        chk(32'(irq[2]), 0, "R9 no event yet");
        idle(1);
        chk(32'(irq[2]), 1, "R7 event at limit");
        chk(32'(irq[1:0]), 0, "R1 other channels quiet");
        rd(ra('h54,2), 32'h1, "R8 status read");
        chk(32'(irq[2]), 0, "R8 cleared by read");
        idle(3);
        chk(32'(irq[2]), 0, "R7 before second event");
        idle(1);
        chk(32'(irq[2]), 1, "R7 second event");
        rd(ra('h18,2), 32'h0, "R7 count wrapped");
        idle(3);
        rd(ra('h54,2), 32'h1, "R8 read with event");
        chk(32'(irq[2]), 1, "R8 event wins");
        rd(ra('h54,2), 32'h1, "R8 reread");
        chk(32'(irq[2]), 0, "R8 cleared");
        rd(ra('h24,2), 32'h4, "R1 interval rw");
        // R9 event without enable on channel 1, limit 2
        wr(ra('h24,1), 32'h2);
        wr(ra('h0C,1), 32'h12);
        idle(5);
        chk(32'(irq[1]), 0, "R9 masked");
        rd(ra('h54,1), 32'h1, "R9 status set while masked");
        idle(1);
        chk(32'(exp_q.size()), 0, "R1 all reads returned");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule